// File: doc/BRIEF.md
# Operate Execution Unit with Condition Flags

This block runs the arithmetic and logic class of a small 16-bit load/store machine: two's complement addition, bitwise AND and bitwise complement. It holds eight 16-bit general registers and a three-bit sign flag register. A host presents a 16-bit instruction word with a one-cycle start strobe. The unit decodes it, reads its sources, computes the result in one phase, commits the destination register and the flags in the next, and then pulses `done`.

The control is a three-state machine. `S_IDLE` waits for `start` and captures the instruction (transition *accept*). `S_EXEC` reads the sources, drives the ALU and latches the result and its flags (transition *compute*, always taken). `S_WRITE` loads the destination register and the flags if the encoding was legal (transition *commit*, always taken back to `S_IDLE`). `done` is a registered pulse that marks the cycle in which the committed state becomes visible. A combinational debug port reads any register, and the flags are always visible on their own port.

Top module: `opx_unit`

## Requirements
- R1: After reset all eight registers read zero, `flags` reads 3'b010 (Z only) and `done` is low.
- R2: Opcode bits 15:12 = 4'b0001 adds the first source (bits 8:6) and the second operand modulo 2^16 and writes the sum to the register named by bits 11:9.
- R3: Opcode 4'b0101 writes the bitwise AND of the two operands. An AND with immediate zero clears the destination.
- R4: Opcode 4'b1001 with bits 5:0 = 6'b111111 writes the bitwise complement of the first source.
- R5: For add and AND, bit 5 = 1 takes bits 4:0 sign-extended to 16 bits as the second operand. Bit 5 = 0 with bits 4:3 = 2'b00 takes the register named by bits 2:0.
- R6: Every committed instruction sets `flags` = {N,Z,P} from its 16-bit result: bit 2 if bit 15 is set, bit 1 if the result is zero, bit 0 otherwise. Exactly one flag is set at all times.
- R7: A `start` sampled in `S_IDLE` commits the result on the second clock edge after it. `done` is high for exactly the one cycle after that edge. A `start` seen outside `S_IDLE` is ignored.
- R8: Any other opcode, a complement whose bits 5:0 are not all ones, or a register-mode add/AND with bits 4:3 non-zero changes no register and no flag. `done` still pulses.
- R9: The destination may equal a source. The source value from before the instruction is used.
- R10: `dbg_data` shows the register selected by `dbg_sel` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Instruction strobe, sampled in idle |
| instr | input | 16 | Instruction word |
| done | output | 1 | One-cycle completion pulse |
| dbg_sel | input | 3 | Register index for the debug read |
| dbg_data | output | 16 | Contents of the selected register |
| flags | output | 3 | Sign flags {N,Z,P} |

## Verification
The hardest situation to reach from the ports is a `start` that arrives while an instruction is still in flight. With a one-cycle strobe the bench never shows it by accident. The stimulus therefore holds `start` high for two cycles and swaps the instruction word in the second cycle. The bench then checks that only the first word commits and that no second `done` follows. Undefined encodings can only be told apart from legal ones by what stays unchanged. Each one is therefore aimed at a register and a flag state whose values are already known, and both are read back after its `done`.

// File: rtl/opx_pkg.sv
package opx_pkg;

    localparam int XLEN   = 16;
    localparam int NREG   = 8;
    localparam int RIDX   = $clog2(NREG);
    localparam int IMMW   = 5;
    localparam int OPCW   = 4;

    localparam logic [OPCW-1:0] OPC_ADD = 4'b0001;
    localparam logic [OPCW-1:0] OPC_AND = 4'b0101;
    localparam logic [OPCW-1:0] OPC_NOT = 4'b1001;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_EXEC  = 2'd1,
        S_WRITE = 2'd2
    } state_e;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_AND = 2'd1,
        ALU_INV = 2'd2
    } alu_op_e;

    typedef struct packed {
        logic            legal;
        alu_op_e         op;
        logic            use_imm;
        logic [RIDX-1:0] dst;
        logic [RIDX-1:0] src1;
        logic [RIDX-1:0] src2;
        logic [XLEN-1:0] imm;
    } dec_t;

endpackage

// File: rtl/opx_decode.sv
module opx_decode
    import opx_pkg::*;
(
    input  logic [XLEN-1:0] word,
    output dec_t            dec
);

    logic [OPCW-1:0] opc;
    logic            mode_bit;

    assign opc      = word[XLEN-1 -: OPCW];
    assign mode_bit = word[IMMW];

    always_comb begin
        dec         = '0;
        dec.op      = ALU_ADD;
        dec.dst     = word[11:9];
        dec.src1    = word[8:6];
        dec.src2    = word[RIDX-1:0];
        dec.use_imm = mode_bit;
        dec.imm     = {{(XLEN-IMMW){word[IMMW-1]}}, word[IMMW-1:0]};
        case (opc)
            OPC_ADD: begin
                dec.op    = ALU_ADD;
                dec.legal = mode_bit | (word[IMMW-1:RIDX] == '0);
            end
            OPC_AND: begin
                dec.op    = ALU_AND;
                dec.legal = mode_bit | (word[IMMW-1:RIDX] == '0);
            end
            OPC_NOT: begin
                dec.op      = ALU_INV;
                dec.use_imm = 1'b0;
                dec.legal   = (word[IMMW:0] == '1);
            end
            default: begin
                dec.legal = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/opx_alu.sv
module opx_alu
    import opx_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic [2:0]   nzp
);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_AND: y = a & b;
            ALU_INV: y = ~a;
            default: y = '0;
        endcase
    end

    logic is_neg;
    logic is_zero;

    assign is_neg  = y[W-1];
    assign is_zero = (y == '0);
    assign nzp     = {is_neg, is_zero, ~is_neg & ~is_zero};

endmodule

// File: rtl/opx_regfile.sv
module opx_regfile
    import opx_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int N  = NREG,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    input  logic [AW-1:0] raddr_d,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b,
    output logic [W-1:0]  rdata_d
);

    logic [W-1:0] cells [N];

    for (genvar g = 0; g < N; g++) begin : g_cell
        logic [W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (we && (waddr == AW'(g))) begin
                q <= wdata;
            end
        end
        assign cells[g] = q;
    end

    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];
    assign rdata_d = cells[raddr_d];

endmodule

// File: rtl/opx_unit.sv
module opx_unit
    import opx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [15:0]     instr,
    output logic            done,
    input  logic [2:0]      dbg_sel,
    output logic [15:0]     dbg_data,
    output logic [2:0]      flags
);

    state_e          state_q;
    state_e          state_d;
    logic [XLEN-1:0] ir_q;
    dec_t            dec;
    logic [XLEN-1:0] src_a;
    logic [XLEN-1:0] src_b;
    logic [XLEN-1:0] opnd_b;
    logic [XLEN-1:0] alu_y;
    logic [2:0]      alu_nzp;
    logic [XLEN-1:0] res_q;
    logic [2:0]      nzp_q;
    logic            legal_q;
    logic [RIDX-1:0] dst_q;
    logic            wr_en;

    opx_decode u_dec (
        .word (ir_q),
        .dec  (dec)
    );

    opx_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en),
        .waddr   (dst_q),
        .wdata   (res_q),
        .raddr_a (dec.src1),
        .raddr_b (dec.src2),
        .raddr_d (dbg_sel),
        .rdata_a (src_a),
        .rdata_b (src_b),
        .rdata_d (dbg_data)
    );

    assign opnd_b = dec.use_imm ? dec.imm : src_b;

    opx_alu #(.W(XLEN)) u_alu (
        .op  (dec.op),
        .a   (src_a),
        .b   (opnd_b),
        .y   (alu_y),
        .nzp (alu_nzp)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: accept, compute, commit
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_EXEC;
            S_EXEC:  state_d = S_WRITE;
            S_WRITE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // datapath registers per state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_q    <= '0;
            res_q   <= '0;
            nzp_q   <= 3'b010;
            legal_q <= 1'b0;
            dst_q   <= '0;
            flags   <= 3'b010;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) ir_q <= instr;
                end
                S_EXEC: begin
                    res_q   <= alu_y;
                    nzp_q   <= alu_nzp;
                    legal_q <= dec.legal;
                    dst_q   <= dec.dst;
                end
                S_WRITE: begin
                    if (legal_q) flags <= nzp_q;
                end
                default: ;
            endcase
        end
    end

    assign wr_en = (state_q == S_WRITE) && legal_q;

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= (state_q == S_WRITE);
        end
    end

endmodule

// File: rtl/opx_unit_chk.sv
module opx_unit_chk
    import opx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       done,
    input  logic [2:0] flags,
    input  state_e     state
);

    // R6: exactly one sign flag at all times
    a_r6_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(flags) == 1);

    // R7: start in idle is accepted
    a_r7_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start) |=> (state == S_EXEC));

    // R7: compute phase always leads to commit
    a_r7_compute: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EXEC) |=> (state == S_WRITE));

    // R7: commit raises done in the next cycle
    a_r7_commit_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WRITE) |=> (done && state == S_IDLE));

    // R7: done is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: flags only move at a commit
    a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_WRITE) |=> $stable(flags));

endmodule

bind opx_unit opx_unit_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .done  (done),
    .flags (flags),
    .state (state_q)
);

// File: tb/test_opx_unit.sv
module test_opx_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic        done;
    logic [2:0]  dbg_sel = '0;
    logic [15:0] dbg_data;
    logic [2:0]  flags;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    localparam logic [2:0] FN = 3'b100;
    localparam logic [2:0] FZ = 3'b010;
    localparam logic [2:0] FP = 3'b001;

    // {instr, dst, expected value, expected flags}
    localparam int NV = 10;
    localparam logic [37:0] VEC [NV] = '{
        {16'h1225, 3'd1, 16'h0005, FP},  // R2 R5 add imm +5
        {16'h143F, 3'd2, 16'hFFFF, FN},  // R2 R5 add imm -1
        {16'h1642, 3'd3, 16'h0004, FP},  // R2 R5 add reg, wraps
        {16'h987F, 3'd4, 16'hFFFA, FN},  // R4 not
        {16'h5B03, 3'd5, 16'h0000, FZ},  // R3 and reg
        {16'h1CB0, 3'd6, 16'hFFEF, FN},  // R5 add imm -16
        {16'h5DA0, 3'd6, 16'h0000, FZ},  // R3 R9 and imm 0 clears
        {16'h1241, 3'd1, 16'h000A, FP},  // R9 r1 + r1
        {16'h5EAF, 3'd7, 16'h000F, FP},  // R3 R5 and imm 15
        {16'h9FFF, 3'd7, 16'hFFF0, FN}   // R4 R9 not in place
    };

    opx_unit i_opx_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .instr    (instr),
        .done     (done),
        .dbg_sel  (dbg_sel),
        .dbg_data (dbg_data),
        .flags    (flags)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic read_reg(input logic [2:0] idx, output logic [15:0] val);
        dbg_sel = idx;
        #1;
        val = dbg_data;
    endtask

    // issue one instruction and wait for done; checks the latency
    task automatic run(input logic [15:0] word);
        int lat;
        @(negedge clk);
        instr = word;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk("R7 latency", 16'(lat), 16'd3);
    endtask

    initial begin
        logic [15:0] v;
        logic [37:0] e;
        int dn;
        repeat (3) @(negedge clk);

        // R1 reset state
        for (int i = 0; i < 8; i++) begin
            read_reg(3'(i), v);
            chk("R1 reg after reset", v, 16'h0000);
        end
        chk("R1 flags after reset", {13'd0, flags}, {13'd0, FZ});
        chk("R1 done after reset", {15'd0, done}, 16'd0);
        rst_n = 1'b1;

        // table walk: R2 R3 R4 R5 R6 R9 R10
        for (int i = 0; i < NV; i++) begin
            e = VEC[i];
            run(e[37:22]);
            read_reg(e[21:19], v);
            chk("R2/R3/R4/R5/R9 result", v, e[18:3]);
            chk("R6 flags", {13'd0, flags}, {13'd0, e[2:0]});
        end

        // R10 full register file readback
        read_reg(3'd0, v); chk("R10 r0", v, 16'h0000);
        read_reg(3'd1, v); chk("R10 r1", v, 16'h000A);
        read_reg(3'd2, v); chk("R10 r2", v, 16'hFFFF);
        read_reg(3'd3, v); chk("R10 r3", v, 16'h0004);
        read_reg(3'd4, v); chk("R10 r4", v, 16'hFFFA);
        read_reg(3'd5, v); chk("R10 r5", v, 16'h0000);
        read_reg(3'd6, v); chk("R10 r6", v, 16'h0000);
        read_reg(3'd7, v); chk("R10 r7", v, 16'hFFF0);

        // R8 complement with bad low bits aimed at r0, flags stay N
        run(16'h907E);
        read_reg(3'd0, v);
        chk("R8 bad not reg", v, 16'h0000);
        chk("R8 bad not flags", {13'd0, flags}, {13'd0, FN});
        // R8 load opcode aimed at r7
        run(16'h2E05);
        read_reg(3'd7, v);
        chk("R8 other opcode reg", v, 16'hFFF0);
        chk("R8 other opcode flags", {13'd0, flags}, {13'd0, FN});
        // R8 register mode with bits 4:3 set aimed at r0
        run(16'h1052);
        read_reg(3'd0, v);
        chk("R8 reg mode bad bits", v, 16'h0000);
        chk("R8 reg mode flags", {13'd0, flags}, {13'd0, FN});

        // R7 start held while busy: second word must be ignored
        @(negedge clk);
        instr = 16'h1021;          // add r0, r0, #1
        start = 1'b1;
        @(negedge clk);
        instr = 16'h1023;          // add r0, r0, #3 (busy)
        @(negedge clk);
        start = 1'b0;
        dn = 0;
        for (int k = 0; k < 8; k++) begin
            if (done) dn++;
            @(negedge clk);
        end
        chk("R7 single done", 16'(dn), 16'd1);
        read_reg(3'd0, v);
        chk("R7 busy start ignored", v, 16'h0001);
        chk("R6 flags positive", {13'd0, flags}, {13'd0, FP});

        // R1 reset in the middle of use
        rst_n = 1'b0;
        #1;
        for (int i = 0; i < 8; i++) begin
            read_reg(3'(i), v);
            chk("R1 reg after second reset", v, 16'h0000);
        end
        chk("R1 flags after second reset", {13'd0, flags}, {13'd0, FZ});
        chk("R1 done after second reset", {15'd0, done}, 16'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule